// File: doc/BRIEF.md
# Adaptive Min-Max Threshold Slicer

This block turns a stream of oversampled multi-bit amplitude samples into a one-bit stream, as the front end of a line-code receiver. Each accepted sample enters a moving-sum filter whose span is exactly half a bit period. The filtered value is then compared against a threshold that follows the signal. The threshold is the midpoint of the largest and smallest filtered values in a rolling window of two bit periods. That window is the shortest span certain to hold both a full high level and a full low level, so the threshold settles between the two signal levels whatever the amplitude or offset.

Samples arrive with a valid strobe and can have gaps of any length between them. Each accepted sample produces one decision on the following clock cycle, once the filter and the window have both been filled since reset. The filtered value is kept as a sum, not as an average. Comparing a sum against the midpoint of sums gives the same decision without a divider.

Top module: `minmax_slicer`

## Requirements
- R1: After reset, `out_valid` stays low for the first SPB/2 + 2*SPB - 2 accepted samples (18 at SPB=8). It is asserted for the sample after those and for every sample from then on.
- R2: A decision appears on `out_valid`/`out_bit` exactly one clock after the cycle in which `in_valid` was high. `out_valid` is low in any cycle that follows a cycle without `in_valid`. Idle cycles change no internal state and do not change `out_bit`.
- R3: The filtered value of sample i is the sum of samples i-SPB/2+1 through i. Samples before the first one after reset count as zero.
- R4: The threshold for sample i is floor((max+min)/2), where max and min are taken over the filtered values of samples i-2*SPB+1 through i, inclusive.
- R5: `out_bit` is 1 when the filtered value is strictly greater than the threshold, and 0 otherwise.
- R6: A constant input, at any level, produces `out_bit` = 0 for every valid decision, because the filtered value then equals the threshold.
- R7: Full-scale samples (all ones at width W) are summed and compared without wraparound.
- R8: Reset discards all sample history. Decisions after a reset depend only on samples accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when `in_sample` holds a new sample |
| in_sample | input | W | Unsigned amplitude sample |
| out_valid | output | 1 | High for one cycle per decision |
| out_bit | output | 1 | Sliced bit, held between decisions |

## Verification
The hardest case to reach is a decision where the filtered value lands exactly on the threshold. This only happens when the window's extremes and the current sum line up. The bench reaches it with constant runs at several levels, where max equals min equals the current value. It also uses clean square patterns, whose ramps pass through the midpoint. Noisy and ramp inputs carry random idle gaps between samples, to show that stalls neither shift the window nor disturb the held output. All decisions are compared against a model that recomputes the sums and window extremes from the stored samples.

// File: rtl/minmax_slicer.sv
module minmax_slicer #(
  parameter int SPB = 8,
  parameter int W   = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  output logic         out_valid,
  output logic         out_bit
);
  localparam int HALF = SPB / 2;
  localparam int WIN  = 2 * SPB;
  localparam int SW   = W + $clog2(HALF) + 1;
  localparam int LIM  = HALF + WIN - 2;
  localparam int CW   = $clog2(LIM + 1);

  logic [W-1:0]  raw_q [HALF];
  logic [SW-1:0] fbuf  [WIN-1];
  logic [SW-1:0] sum_q, sum_nx, mx, mn, thr;
  logic [CW-1:0] cnt_q;
  logic          ready;

  assign ready  = (cnt_q == CW'(LIM));
  assign sum_nx = sum_q + SW'(in_sample) - SW'(raw_q[HALF-1]);

  always_comb begin
    mx = sum_nx;
    mn = sum_nx;
    for (int i = 0; i < WIN-1; i++) begin
      if (fbuf[i] > mx) mx = fbuf[i];
      if (fbuf[i] < mn) mn = fbuf[i];
    end
  end

  assign thr = SW'(({1'b0, mx} + {1'b0, mn}) >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF; i++) raw_q[i] <= '0;
      for (int i = 0; i < WIN-1; i++) fbuf[i] <= '0;
      sum_q     <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid && ready;
      if (in_valid) begin
        raw_q[0] <= in_sample;
        for (int i = 1; i < HALF; i++) raw_q[i] <= raw_q[i-1];
        fbuf[0] <= sum_nx;
        for (int i = 1; i < WIN-1; i++) fbuf[i] <= fbuf[i-1];
        sum_q   <= sum_nx;
        out_bit <= sum_nx > thr;
        if (!ready) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r1_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sum_q) && $stable(out_bit) && $stable(cnt_q));

  a_r6_flat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ready && (mx == mn) |=> !out_bit);

  a_r5_peak_one: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ready && (mx != mn) && (sum_nx == mx) |=> out_bit);
endmodule

// File: tb/minmax_slicer_bench.sv
module minmax_slicer_bench;
  localparam int SPB  = 8;
  localparam int W    = 12;
  localparam int HALF = SPB / 2;
  localparam int WIN  = 2 * SPB;
  localparam int LIM  = HALF + WIN - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_sample = '0;
  logic out_valid, out_bit;

  int total = 0, bad = 0, n = 0, cyc = 0;
  int xs [0:2047];
  logic [15:0] lf = 16'hACE1;
  bit done = 0;

  always #2.5 clk = ~clk;

  minmax_slicer #(.SPB(SPB), .W(W)) u_minmax_slicer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_bit(out_bit));

  function automatic int filt(int i);
    int s = 0;
    for (int j = i - HALF + 1; j <= i; j++) if (j >= 0) s += xs[j];
    return s;
  endfunction

  function automatic bit exp_bit(int i);
    int mx = filt(i), mn = filt(i), v;
    for (int j = i - WIN + 1; j <= i; j++) begin
      v = filt(j);
      if (v > mx) mx = v;
      if (v < mn) mn = v;
    end
    return filt(i) > ((mx + mn) >> 1);
  endfunction

  task automatic check(bit cond, string req, int act, int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (sample %0d)", req, act, expv, n);
    end
  endtask

  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_bit == 1'b0, "R8 reset state", {out_valid, out_bit}, 0);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic idle(int k);
    bit held;
    for (int c = 0; c < k; c++) begin
      held = out_bit;
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R2 idle valid", out_valid, 0);
      check(out_bit == held, "R2 idle hold", out_bit, held);
    end
  endtask

  task automatic push(int v, string req);
    bit e;
    xs[n] = v;
    in_sample = W'(v);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == (n >= LIM), "R1 warmup valid", out_valid, (n >= LIM));
    if (n >= LIM) begin
      e = exp_bit(n);
      check(out_bit == e, req, out_bit, e);
    end
    n++;
  endtask

  initial begin
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int b = 0; b < 40; b++) begin
      step_lfsr();
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < HALF; s++)
          push(((lf[0] ^ h[0]) != 0) ? 4095 : 0, "R5 clean square full-scale R7");
    end

    do_reset();
    for (int b = 0; b < 60; b++) begin
      step_lfsr();
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < HALF; s++) begin
          step_lfsr();
          if (lf[3:2] == 2'b11) idle(int'(lf[5:4]) + 1);
          push(2048 + (((lf[9] ^ h[0]) != 0) ? 1500 : -1500) + int'(lf[15:6]) - 511,
               "R4 noisy threshold");
        end
    end

    foreach (xs[k]) if (k < 4) ;
    for (int lv = 0; lv < 4; lv++) begin
      do_reset();
      for (int s = 0; s < 30; s++) begin
        push((lv == 3) ? 4095 : lv * 1365, "R6 constant level");
        check(n <= LIM || out_bit == 1'b0, "R6 flat zero", out_bit, 0);
      end
    end

    do_reset();
    for (int s = 0; s < 200; s++) begin
      step_lfsr();
      if (lf[1:0] == 2'b00) idle(2);
      push(((s % 40) < 20) ? (s % 40) * 200 : (40 - (s % 40)) * 200, "R3 ramp sum");
    end

    do_reset();
    for (int s = 0; s < 25; s++) push(((s / 3) % 2 == 1) ? 4095 : 17, "R8 fresh history");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule